// File: doc/BRIEF.md
# Edge-Triggered Vectored Interrupt Arbiter

This block sits in front of a playback sequencer. It turns activity on four trigger pins, plus one start-up event, into vector numbers. Each pin idles high. The pin is synchronised and debounced, and the debounce interval is either short or long, chosen by a mode input. After debounce, falling and rising edges are seen as separate request sources. Each source is gated by its own bit in one of two 4-bit enable stores, which the sequencer loads through a small configuration write port.

Every enabled edge sets a pending flag, and the flag stays set until that source is served. The start-up request is raised once, a set number of timebase ticks after reset is released. A jump request from the sequencer is a level input and has the lowest rank. A fixed priority picks one request. Its vector is offered with a valid strobe and held until the sequencer acknowledges it.

The control state machine has three states. ST_BOOT counts the start-up delay; edges may already become pending here. ST_BOOT goes to ST_IDLE when the count expires, and this also raises the start-up request. ST_IDLE goes to ST_OFFER in the first cycle in which any request exists, and it latches the winner and its vector. ST_OFFER goes back to ST_IDLE on the acknowledge, which clears only the served source. All counters advance on a shared clock-enable tick, so the intervals scale through parameters.

Top module: `trig_vector_arbiter`

## Requirements
- R1: After reset, vec_valid is low and every trigger edge (both edges on all four pins) is enabled.
- R2: The start-up vector 32 is the first vector offered. It appears POI_TICKS timebase ticks after reset release, ahead of any trigger that became pending during that delay.
- R3: A pin change is accepted only after the synchronised level has differed from the debounced level for a full debounce interval. That interval is DEB_LONG_TICKS ticks when deb_long is 1 and DEB_SHORT_TICKS ticks when it is 0. Shorter pulses produce nothing.
- R4: Falling edges on pins 0, 1, 2 and 3 give vectors 0, 1, 8 and 9. Rising edges give 4, 5, 12 and 13.
- R5: A write with cfg_we=1 and cfg_sel=0 loads the enables of pins 0/1; cfg_sel=1 loads those of pins 2/3. In cfg_wdata, bit0 is the first pin's falling edge, bit1 the second pin's falling edge, bit4 the first pin's rising edge and bit5 the second pin's rising edge. Bits 2, 3, 6 and 7 are ignored. A 1 enables the edge.
- R6: An edge that arrives while it is disabled never becomes pending, and enabling it later does not produce its vector.
- R7: A pending flag stays set until its vector is acknowledged. While vec_valid is high and vec_ack is low, vec_num is held. vec_ack drops vec_valid on the next cycle and clears only the served source.
- R8: The priority, from highest, is: start-up, pin0 fall, pin0 rise, pin1 fall, pin1 rise, pin2 fall, pin2 rise, pin3 fall, pin3 rise, jump.
- R9: A high jump_req is served only when nothing else is pending. The vector offered is jump_vec, captured when the request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 4 | Raw trigger pins, idle high |
| deb_long | input | 1 | 1 selects the long debounce interval |
| cfg_we | input | 1 | Enable store write strobe |
| cfg_sel | input | 1 | 0: pins 0/1 store, 1: pins 2/3 store |
| cfg_wdata | input | 8 | Enable write data |
| jump_req | input | 1 | Lowest-rank jump request (level) |
| jump_vec | input | 8 | Vector for the jump request |
| vec_ack | input | 1 | Acknowledge of the offered vector |
| vec_valid | output | 1 | A vector is offered |
| vec_num | output | 8 | Offered vector number |

## Verification
The hardest case to reach is several sources pending at the same moment, so that the priority chain actually decides between them. The bench drops all four pins in the same cycle while holding the acknowledge back. It then raises the jump request and drains the queue one acknowledge at a time, expecting 0, 1, 8, 9 and then the jump vector. Releasing all pins together checks the rising chain in the same way. The start-up case is reached by pressing a pin during the boot delay, so that the start-up vector has to win over a request that is already waiting.

// File: rtl/trv_pkg.sv
package trv_pkg;

    localparam int N_PINS = 4;
    localparam int N_SRC  = 2 * N_PINS + 2;   // start-up, 8 edges, jump
    localparam int JUMP_IDX = N_SRC - 1;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_OFFER = 2'd2
    } trv_state_e;

    // Source index order equals priority order (0 = highest).
    function automatic logic [7:0] vec_of_index(input int idx, input logic [7:0] jv);
        logic [7:0] v;
        int pin;
        if (idx == 0) begin
            v = 8'd32;
        end else if (idx == JUMP_IDX) begin
            v = jv;
        end else begin
            pin = (idx - 1) / 2;
            v = 8'((pin / 2) * 8 + (pin % 2) + (((idx - 1) % 2) * 4));
        end
        return v;
    endfunction

    function automatic logic [7:0] vec_of_grant(input logic [N_SRC-1:0] g, input logic [7:0] jv);
        logic [7:0] v;
        v = 8'd0;
        for (int i = 0; i < N_SRC; i++) begin
            if (g[i]) v = v | vec_of_index(i, jv);
        end
        return v;
    endfunction

endpackage

// File: rtl/trv_tick_gen.sv
module trv_tick_gen #(
    parameter int DIV = 300
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/trv_pin_filter.sv
module trv_pin_filter #(
    parameter int SHORT_TICKS = 4,
    parameter int LONG_TICKS  = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic long_sel,
    input  logic pin_raw,
    output logic fall_pulse,
    output logic rise_pulse
);
    localparam int CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LIM_S = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] LIM_L = CW'(LONG_TICKS - 1);

    logic          meta_q, sync_q, stable_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          accept;

    // two-flop synchroniser, idle level high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
        end
    end

    assign lim    = long_sel ? LIM_L : LIM_S;
    assign accept = (sync_q != stable_q) && tick && (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_q   <= 1'b1;
            cnt_q      <= '0;
            fall_pulse <= 1'b0;
            rise_pulse <= 1'b0;
        end else begin
            fall_pulse <= accept && !sync_q;
            rise_pulse <= accept &&  sync_q;
            if (sync_q == stable_q) begin
                cnt_q <= '0;
            end else if (accept) begin
                stable_q <= sync_q;
                cnt_q    <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_pulse && rise_pulse));

    p_fall_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |-> !stable_q);

    p_rise_after_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |-> stable_q);

endmodule

// File: rtl/trv_prio_pick.sv
module trv_prio_pick #(
    parameter int N = 10
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assign any = |req;

    always_comb begin
        p_grant_onehot_r8: assert ($onehot0(grant));
        p_grant_when_req_r8: assert (!any || (grant != '0));
    end

endmodule

// File: rtl/trig_vector_arbiter.sv
module trig_vector_arbiter
    import trv_pkg::*;
#(
    parameter int TICK_DIV        = 300,
    parameter int DEB_SHORT_TICKS = 4,
    parameter int DEB_LONG_TICKS  = 500,
    parameter int POI_TICKS       = 1600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] trig_in,
    input  logic       deb_long,
    input  logic       cfg_we,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    input  logic       jump_req,
    input  logic [7:0] jump_vec,
    input  logic       vec_ack,
    output logic       vec_valid,
    output logic [7:0] vec_num
);
    localparam int N_EDGE = 2 * N_PINS;
    localparam int BW = $clog2(POI_TICKS + 1);
    localparam logic [BW-1:0] BOOT_LAST = BW'(POI_TICKS - 1);

    trv_state_e state_q, state_d;

    logic               tick;
    logic [N_PINS-1:0]  fall_p, rise_p;
    logic [N_EDGE-1:0]  edge_req, en_mask, pend_trig;
    logic               pend_poi;
    logic [3:0]         en_pair [2];
    logic [BW-1:0]      boot_cnt;
    logic               boot_hit;
    logic [N_SRC-1:0]   req, grant, grant_q, clr;
    logic               any_req;
    logic [7:0]         vec_q;
    logic               unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[7:6], cfg_wdata[3:2]};

    trv_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    // per-pin filtering and enable mapping
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        trv_pin_filter #(
            .SHORT_TICKS(DEB_SHORT_TICKS),
            .LONG_TICKS (DEB_LONG_TICKS)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .long_sel  (deb_long),
            .pin_raw   (trig_in[p]),
            .fall_pulse(fall_p[p]),
            .rise_pulse(rise_p[p])
        );
        assign edge_req[2*p]     = fall_p[p];
        assign edge_req[2*p + 1] = rise_p[p];
        assign en_mask[2*p]      = en_pair[p/2][p%2];
        assign en_mask[2*p + 1]  = en_pair[p/2][2 + (p%2)];
    end

    // enable stores: [0] fall first, [1] fall second, [2] rise first, [3] rise second
    for (genvar k = 0; k < 2; k++) begin : g_en
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_pair[k] <= 4'hF;
            else if (cfg_we && (cfg_sel == 1'(k)))
                en_pair[k] <= {cfg_wdata[5], cfg_wdata[4], cfg_wdata[1], cfg_wdata[0]};
        end
    end

    // start-up delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            boot_cnt <= '0;
        else if (state_q == ST_BOOT && tick && !boot_hit)
            boot_cnt <= boot_cnt + 1'b1;
    end
    assign boot_hit = (state_q == ST_BOOT) && tick && (boot_cnt == BOOT_LAST);

    // pending flags
    assign clr = (state_q == ST_OFFER && vec_ack) ? grant_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_trig <= '0;
            pend_poi  <= 1'b0;
        end else begin
            pend_trig <= (pend_trig & ~clr[N_EDGE:1]) | (edge_req & en_mask);
            pend_poi  <= (pend_poi & ~clr[0]) | boot_hit;
        end
    end

    assign req = {jump_req, pend_trig, pend_poi};

    trv_prio_pick #(.N(N_SRC)) u_pick (
        .req  (req),
        .grant(grant),
        .any  (any_req)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  if (boot_hit) state_d = ST_IDLE;
            ST_IDLE:  if (any_req)  state_d = ST_OFFER;
            ST_OFFER: if (vec_ack)  state_d = ST_IDLE;
            default:                state_d = ST_BOOT;
        endcase
    end

    // winner capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            vec_q   <= 8'd0;
        end else if (state_q == ST_IDLE && any_req) begin
            grant_q <= grant;
            vec_q   <= vec_of_grant(grant, jump_vec);
        end
    end

    // outputs
    always_comb begin
        vec_valid = (state_q == ST_OFFER);
        vec_num   = vec_q;
    end

    // ---------------- assertions ----------------
    logic seen_valid;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seen_valid <= 1'b0;
        else if (vec_valid) seen_valid <= 1'b1;
    end

    p_poi_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !seen_valid) |-> (vec_num == 8'd32));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_ack) |=> (vec_valid && $stable(vec_num)));

    p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ack) |=> !vec_valid);

    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend_trig & edge_req & ~en_mask) != '0) |=>
        ((pend_trig & $past(~pend_trig & edge_req & ~en_mask)) == '0));

    p_boot_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_valid && !pend_poi && state_q == ST_BOOT) |=> !vec_valid);

endmodule

// File: tb/tb_trig_vector_arbiter.sv
module tb_trig_vector_arbiter;

    localparam int TDIV = 4;
    localparam int DSH  = 3;
    localparam int DLG  = 12;
    localparam int POI  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] trig_in = 4'hF;
    logic       deb_long = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       jump_req = 1'b0;
    logic [7:0] jump_vec = 8'h00;
    logic       vec_ack = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_num;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    trig_vector_arbiter #(
        .TICK_DIV(TDIV), .DEB_SHORT_TICKS(DSH), .DEB_LONG_TICKS(DLG), .POI_TICKS(POI)
    ) dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .deb_long(deb_long),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .jump_req(jump_req), .jump_vec(jump_vec), .vec_ack(vec_ack),
        .vec_valid(vec_valid), .vec_num(vec_num)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_vec(input int exp, input string req, input int timeout, input bit drop_jump);
        int n = 0;
        while (!vec_valid && n < timeout) begin
            @(negedge clk);
            n++;
        end
        if (!vec_valid) begin
            check(1'b0, req, -1, exp);
        end else begin
            check(vec_num == 8'(exp), req, int'(vec_num), exp);
            vec_ack = 1'b1;
            if (drop_jump) jump_req = 1'b0;
            @(negedge clk);
            vec_ack = 1'b0;
        end
    endtask

    task automatic expect_none(input string req, input int span);
        bit seen = 1'b0;
        int got = 0;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            if (vec_valid && !seen) begin
                seen = 1'b1;
                got = int'(vec_num);
                vec_ack = 1'b1;
                @(negedge clk);
                vec_ack = 1'b0;
            end
        end
        check(!seen, req, seen ? got : -1, -1);
    endtask

    task automatic cfg_write(input bit sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
        $finish;
    end

    initial begin
        int t;
        logic [7:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: boot window, with pin0 pressed during the delay
        t = 0;
        while (!vec_valid && t < 200) begin
            @(negedge clk);
            t++;
            if (t == 1) check(!vec_valid, "R1 reset valid low", int'(vec_valid), 0);
            if (t == 20) trig_in[0] = 1'b0;
        end
        check(t >= POI * TDIV - 6 && t <= POI * TDIV + 8, "R2 start-up delay", t, POI * TDIV);
        expect_vec(32, "R2 start-up vector first", 10, 1'b0);
        expect_vec(0, "R8 pending trigger after start-up", 60, 1'b0);
        trig_in[0] = 1'b1;
        expect_vec(4, "R1 R4 default rise enabled", 60, 1'b0);

        // R4 / R5 / R6: sweep pins x enable combinations, don't-care bits set
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                logic [7:0] d;
                int fv;
                d = 8'hCC | (8'(c & 1) << (p % 2)) | (8'((c >> 1) & 1) << (4 + p % 2));
                cfg_write(p / 2, d);
                cfg_write(1 - p / 2, 8'hCC);
                fv = (p / 2) * 8 + (p % 2);
                trig_in[p] = 1'b0;
                if (c & 1) expect_vec(fv, "R4 R5 falling vector", 60, 1'b0);
                else       expect_none("R5 R6 falling disabled", 50);
                trig_in[p] = 1'b1;
                if (c & 2) expect_vec(fv + 4, "R4 R5 rising vector", 60, 1'b0);
                else       expect_none("R5 R6 rising disabled", 50);
            end
        end

        // R6: disabled edge then re-enabled leaves nothing behind
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'h00);
        trig_in[1] = 1'b0;
        repeat (50) @(negedge clk);
        cfg_write(1'b0, 8'h33);
        cfg_write(1'b1, 8'h33);
        expect_none("R6 stale edge after re-enable", 50);
        trig_in[1] = 1'b1;
        expect_vec(5, "R6 later enabled edge", 60, 1'b0);

        // R9: lone jump request
        jump_vec = 8'h5C;
        @(negedge clk);
        jump_req = 1'b1;
        expect_vec(8'h5C, "R9 lone jump", 10, 1'b1);
        expect_none("R9 jump dropped", 20);

        // R7 / R8 / R9: simultaneous press of all pins
        trig_in = 4'h0;
        repeat (60) @(negedge clk);
        held = vec_num;
        check(vec_valid && held == 8'd0, "R8 first winner", int'(held), 0);
        jump_vec = 8'hA7;
        jump_req = 1'b1;
        repeat (20) @(negedge clk);
        check(vec_valid && vec_num == held, "R7 held without ack", int'(vec_num), int'(held));
        expect_vec(0, "R7 R8 order pin0 fall", 10, 1'b0);
        expect_vec(1, "R7 R8 order pin1 fall", 10, 1'b0);
        expect_vec(8, "R7 R8 order pin2 fall", 10, 1'b0);
        expect_vec(9, "R7 R8 order pin3 fall", 10, 1'b0);
        expect_vec(8'hA7, "R9 jump after triggers", 10, 1'b1);
        trig_in = 4'hF;
        repeat (60) @(negedge clk);
        expect_vec(4,  "R8 order pin0 rise", 10, 1'b0);
        expect_vec(5,  "R8 order pin1 rise", 10, 1'b0);
        expect_vec(12, "R8 order pin2 rise", 10, 1'b0);
        expect_vec(13, "R8 order pin3 rise", 10, 1'b0);

        // R3: short glitch in short mode
        deb_long = 1'b0;
        @(negedge clk);
        trig_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        trig_in[0] = 1'b1;
        expect_none("R3 short glitch ignored", 60);

        // R3: medium pulse in long mode
        deb_long = 1'b1;
        @(negedge clk);
        trig_in[0] = 1'b0;
        repeat (30) @(negedge clk);
        trig_in[0] = 1'b1;
        expect_none("R3 pulse under long interval", 100);

        // R3: long hold accepted
        trig_in[0] = 1'b0;
        expect_vec(0, "R3 long hold accepted", 200, 1'b0);
        trig_in[0] = 1'b1;
        expect_vec(4, "R3 long release accepted", 200, 1'b0);

        summary();
        $finish;
    end

endmodule